// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a bit-serial memory that loads an FPGA running in master serial mode. A bit array of `DEPTH` entries is filled with a computed pattern at start of simulation. Each rising clock edge, while the device is selected, advances a read pointer, and the next stored bit appears on the serial data output. The three-state driver is modelled as a data value (`data_o`) and a separate drive enable (`data_oe`).

Several devices can share one serial line. The cascade output `ceo_n` of one device drives the chip-select `ce_n` of the next. When the last bit of a device has been clocked out, the device stops driving and pulls `ceo_n` low, and the next device takes over the line. The combined reset/output-enable pin `rst_oe` has a polarity set by the parameter `RST_ACTIVE_HIGH`. Its reset level clears the pointer asynchronously. Its other level permits output. When `ser_en` is low, the read path is parked.

The cascade output comes from a three-state machine. `CASC_ARMED` holds `ceo_n` high while the array is being read. The transition *handoff* (the clock edge that consumes the last bit) enters `CASC_PASS`, where `ceo_n` is driven low. The transition *deselect* (an edge that samples `ce_n` high while in `CASC_PASS`) enters `CASC_FOLLOW`, where `ceo_n` copies `ce_n`. The transition *rearm* (the reset level on `rst_oe`, asynchronous, from any state) returns to `CASC_ARMED`.

Top module: `cfg_prom_reader`

## Requirements
- R1: `data_oe` is 1 only when `ser_en` is 1, `ce_n` is 0, `rst_oe` is at its non-reset level and the pointer has not reached `DEPTH`. When `data_oe` is 1, `data_o` carries the addressed bit.
- R2: After reset is released, the bit presented is the one at index k, where k is the number of rising edges counted since then with the device selected. Bit k holds the XOR-reduction of `((k XOR SEED) AND 8'hB5)` taken over the low 8 bits.
- R3: The reset level on `rst_oe` clears the pointer at once, without waiting for a clock. While it is held, no edge advances the pointer. After release, reading restarts at bit 0.
- R4: With `ce_n` high, clock edges leave the pointer unchanged and `data_oe` is 0.
- R5: The edge that consumes bit `DEPTH-1` drops `data_oe` and drives `ceo_n` low together. The pointer then saturates, and further edges neither wrap it nor re-enable the output.
- R6: In `CASC_PASS`, `ceo_n` stays 0. An edge that samples `ce_n` high moves to `CASC_FOLLOW`. From then on, `ceo_n` equals `ce_n` combinationally.
- R7: The reset level forces `ceo_n` high (`CASC_ARMED`). It stays high during a re-read until the last bit is consumed again.
- R8: With `RST_ACTIVE_HIGH`=1 a high `rst_oe` resets and a low one enables. With `RST_ACTIVE_HIGH`=0 the roles swap.
- R9: With `ser_en` low, the pointer holds, `data_oe` is 0 and `ceo_n` is 1, whatever `ce_n` is.
- R10: In a chain of two devices, the shared line carries all bits of the first device and then all bits of the second with no gap. The two devices never drive the line together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; rising edge advances the pointer |
| ser_en | input | 1 | 1 selects read mode; 0 parks the read path |
| ce_n | input | 1 | Active-low chip select |
| rst_oe | input | 1 | Reset / output-enable pin, polarity set by `RST_ACTIVE_HIGH` |
| data_o | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for `data_o` (1 = driving) |
| ceo_n | output | 1 | Active-low cascade enable to the next device |

## Verification
The data bit, `data_oe` and `ceo_n` all settle within the same clock period as the edge that causes them: a pointer step, the last-bit handoff and the `CASC_PASS` to `CASC_FOLLOW` move are each seen one edge after their cause. Reset, `ce_n` in `CASC_FOLLOW`, and `ser_en` or `ce_n` gating of `data_oe` act without any edge. The bench changes inputs at the falling edge and samples one time unit later for the zero-cycle results. For results that need an edge, it samples at the next falling edge, which puts exactly one rising edge between cause and check. Edges are counted in the bench, so every expected bit index is known in advance.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;

    typedef enum logic [1:0] {
        CASC_ARMED  = 2'd0,
        CASC_PASS   = 2'd1,
        CASC_FOLLOW = 2'd2
    } casc_state_t;

    // Preload pattern: parity of the masked low byte of (index ^ seed)
    function automatic logic pattern_bit(input int unsigned idx, input int unsigned seed);
        logic [7:0] v;
        v = 8'(idx ^ seed) & 8'hB5;
        return ^v;
    endfunction

endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned SEED  = 0,
    parameter int unsigned AW    = 11
) (
    input  logic [AW-1:0] rd_ptr,
    output logic          rd_bit
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] FULL = AW'(DEPTH);

    logic [DEPTH-1:0] mem;

    initial begin
        for (int unsigned i = 0; i < DEPTH; i++) begin
            mem[i] = cfg_prom_pkg::pattern_bit(i, SEED);
        end
    end

    always_comb begin
        rd_bit = (rd_ptr < FULL) ? mem[rd_ptr[IW-1:0]] : 1'b0;
    end
endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          rst_hit,
    input  logic          step_en,
    output logic [AW-1:0] ptr,
    output logic          at_end,
    output logic          last_step
);
    localparam logic [AW-1:0] FULL     = AW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    always_ff @(posedge clk or posedge rst_hit) begin
        if (rst_hit) begin
            ptr <= '0;
        end else if (step_en && !at_end) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        at_end    = (ptr == FULL);
        last_step = step_en && (ptr == LAST_IDX);
    end
endmodule

// File: rtl/cfg_cascade_fsm.sv
module cfg_cascade_fsm
    import cfg_prom_pkg::*;
(
    input  logic clk,
    input  logic rst_hit,
    input  logic ser_en,
    input  logic ce_n,
    input  logic last_step,
    output logic ceo_n
);
    casc_state_t state_q, state_d;

    always_ff @(posedge clk or posedge rst_hit) begin
        if (rst_hit) begin
            state_q <= CASC_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CASC_ARMED:  if (ser_en && last_step) state_d = CASC_PASS;
            CASC_PASS:   if (ser_en && ce_n)      state_d = CASC_FOLLOW;
            CASC_FOLLOW: state_d = CASC_FOLLOW;
            default:     state_d = CASC_ARMED;
        endcase
    end

    always_comb begin
        ceo_n = 1'b1;
        if (ser_en) begin
            unique case (state_q)
                CASC_ARMED:  ceo_n = 1'b1;
                CASC_PASS:   ceo_n = 1'b0;
                CASC_FOLLOW: ceo_n = ce_n;
                default:     ceo_n = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader #(
    parameter int unsigned DEPTH           = 1024,
    parameter int unsigned SEED            = 0,
    parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic ser_en,
    input  logic ce_n,
    input  logic rst_oe,
    output logic data_o,
    output logic data_oe,
    output logic ceo_n
);
    localparam int unsigned AW = $clog2(DEPTH + 1);

    logic          rst_hit;
    logic          enabled;
    logic [AW-1:0] rd_ptr;
    logic          at_end;
    logic          last_step;
    logic          rd_bit;

    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_high
            assign rst_hit = rst_oe;
        end else begin : g_rst_low
            assign rst_hit = ~rst_oe;
        end
    endgenerate

    assign enabled = ser_en & ~ce_n & ~rst_hit;

    cfg_addr_counter #(.DEPTH(DEPTH), .AW(AW)) ctr_i (
        .clk       (clk),
        .rst_hit   (rst_hit),
        .step_en   (enabled),
        .ptr       (rd_ptr),
        .at_end    (at_end),
        .last_step (last_step)
    );

    cfg_bit_store #(.DEPTH(DEPTH), .SEED(SEED), .AW(AW)) store_i (
        .rd_ptr (rd_ptr),
        .rd_bit (rd_bit)
    );

    cfg_cascade_fsm casc_i (
        .clk       (clk),
        .rst_hit   (rst_hit),
        .ser_en    (ser_en),
        .ce_n      (ce_n),
        .last_step (last_step),
        .ceo_n     (ceo_n)
    );

    assign data_oe = enabled & ~at_end;
    assign data_o  = data_oe ? rd_bit : 1'b0;
endmodule

// File: rtl/cfg_prom_reader_chk.sv
module cfg_prom_reader_chk #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 11
) (
    input logic          clk,
    input logic          rst_hit,
    input logic          ser_en,
    input logic          ce_n,
    input logic          data_oe,
    input logic          ceo_n,
    input logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] FULL     = AW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    assert_drive_in_range_R1: assert property (@(posedge clk) disable iff (rst_hit)
        data_oe |-> (ptr < FULL));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst_hit)
        (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1));

    assert_hold_deselected_R4: assert property (@(posedge clk) disable iff (rst_hit)
        ce_n |=> $stable(ptr));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst_hit)
        (ptr == FULL) |=> (ptr == FULL));

    assert_handoff_R5: assert property (@(posedge clk) disable iff (rst_hit)
        (ser_en && ptr == FULL && $past(ptr) == LAST_IDX) |-> (!ceo_n && !data_oe));

    assert_ceo_high_reading_R7: assert property (@(posedge clk) disable iff (rst_hit)
        (ptr < FULL) |-> ceo_n);

    assert_parked_R9: assert property (@(posedge clk) disable iff (rst_hit)
        !ser_en |=> $stable(ptr));
endmodule

bind cfg_prom_reader cfg_prom_reader_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk     (clk),
    .rst_hit (rst_hit),
    .ser_en  (ser_en),
    .ce_n    (ce_n),
    .data_oe (data_oe),
    .ceo_n   (ceo_n),
    .ptr     (rd_ptr)
);

// File: tb/cfg_prom_reader_tb_top.sv
module cfg_prom_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_DEPTH   = 16;
    localparam int SEED_A     = 3;
    localparam int SEED_B     = 90;
    localparam int SEED_C     = 41;

    logic clk;
    logic ser_en, ce_n_a, rst_oe;
    logic ce_n_c, rst_oe_c;
    logic data_a, oe_a, ceo_a;
    logic data_b, oe_b, ceo_b;
    logic data_c, oe_c, ceo_c;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    cfg_prom_reader #(.DEPTH(TB_DEPTH), .SEED(SEED_A), .RST_ACTIVE_HIGH(1'b1)) dut_i (
        .clk(clk), .ser_en(ser_en), .ce_n(ce_n_a), .rst_oe(rst_oe),
        .data_o(data_a), .data_oe(oe_a), .ceo_n(ceo_a));

    cfg_prom_reader #(.DEPTH(TB_DEPTH), .SEED(SEED_B), .RST_ACTIVE_HIGH(1'b1)) dut_nxt_i (
        .clk(clk), .ser_en(ser_en), .ce_n(ceo_a), .rst_oe(rst_oe),
        .data_o(data_b), .data_oe(oe_b), .ceo_n(ceo_b));

    cfg_prom_reader #(.DEPTH(TB_DEPTH), .SEED(SEED_C), .RST_ACTIVE_HIGH(1'b0)) dut_lo_i (
        .clk(clk), .ser_en(ser_en), .ce_n(ce_n_c), .rst_oe(rst_oe_c),
        .data_o(data_c), .data_oe(oe_c), .ceo_n(ceo_c));

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic logic ref_bit(input int seed, input int k);
        logic [7:0] v;
        v = 8'(k ^ seed) & 8'hB5;
        return ^v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        chk("R3", "oe_a in reset", oe_a, 0);
        chk("R7", "ceo_a in reset", ceo_a, 1);
        chk("R3", "oe_b in reset", oe_b, 0);
        chk("R8", "oe_c with low pin (active-low reset)", oe_c, 0);
    endtask

    task automatic t_chain_read();
        @(negedge clk);
        rst_oe = 0; ce_n_a = 0;
        #1;
        for (int k = 0; k < 2*TB_DEPTH; k++) begin
            chk("R10", "no double drive", oe_a & oe_b, 0);
            if (k < TB_DEPTH) begin
                chk("R1", "oe_a reading", oe_a, 1);
                chk("R2", "bit from first device", data_a, ref_bit(SEED_A, k));
                chk("R7", "ceo_a high while reading", ceo_a, 1);
            end else begin
                chk("R5", "oe_a after last bit", oe_a, 0);
                chk("R5", "ceo_a low after last bit", ceo_a, 0);
                chk("R10", "bit from second device", data_b, ref_bit(SEED_B, k - TB_DEPTH));
                chk("R10", "oe_b driving", oe_b, 1);
            end
            @(negedge clk);
        end
        for (int j = 0; j < 3; j++) begin
            chk("R5", "oe_a saturated", oe_a, 0);
            chk("R5", "oe_b saturated", oe_b, 0);
            chk("R6", "ceo_b low at chain end", ceo_b, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_follow();
        ce_n_a = 1; #1;
        chk("R6", "ceo_a still low before edge", ceo_a, 0);
        @(negedge clk);
        chk("R6", "ceo_a follows ce high", ceo_a, 1);
        ce_n_a = 0; #1;
        chk("R6", "ceo_a follows ce low", ceo_a, 0);
        ce_n_a = 1; #1;
        chk("R6", "ceo_a follows ce high again", ceo_a, 1);
    endtask

    task automatic t_reset_midread();
        @(negedge clk);
        rst_oe = 1; ce_n_a = 0; #1;
        chk("R7", "ceo_a rearmed by reset", ceo_a, 1);
        chk("R3", "oe_a off in reset", oe_a, 0);
        repeat (2) @(negedge clk);
        rst_oe = 0; #1;
        chk("R3", "restart at bit 0", data_a, ref_bit(SEED_A, 0));
        repeat (5) @(negedge clk);
        chk("R2", "bit 5 on re-read", data_a, ref_bit(SEED_A, 5));
        chk("R7", "ceo_a high on re-read", ceo_a, 1);
        rst_oe = 1; #1;
        chk("R3", "oe_a off mid-read reset", oe_a, 0);
        repeat (3) @(negedge clk);
        chk("R3", "no count while reset held", oe_a, 0);
        rst_oe = 0; #1;
        chk("R3", "bit 0 after mid-read reset", data_a, ref_bit(SEED_A, 0));
        chk("R1", "oe_a back on", oe_a, 1);
    endtask

    task automatic t_standby();
        repeat (2) @(negedge clk);
        chk("R2", "bit 2 before standby", data_a, ref_bit(SEED_A, 2));
        ce_n_a = 1; #1;
        chk("R4", "oe_a off when deselected", oe_a, 0);
        repeat (4) @(negedge clk);
        ce_n_a = 0; #1;
        chk("R4", "pointer held in standby", data_a, ref_bit(SEED_A, 2));
    endtask

    task automatic t_serial_off();
        ser_en = 0; #1;
        chk("R9", "oe_a off when parked", oe_a, 0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R9", "ceo_a high when parked", ceo_a, 1);
            chk("R9", "oe_a off parked", oe_a, 0);
        end
        ser_en = 1; #1;
        chk("R9", "pointer held while parked", data_a, ref_bit(SEED_A, 2));
        @(negedge clk);
        chk("R2", "bit 3 after unpark", data_a, ref_bit(SEED_A, 3));
    endtask

    task automatic t_polarity();
        rst_oe_c = 1; #1;
        chk("R8", "high pin enables active-low part", oe_c, 1);
        chk("R8", "bit 0 on active-low part", data_c, ref_bit(SEED_C, 0));
        repeat (3) @(negedge clk);
        chk("R8", "bit 3 on active-low part", data_c, ref_bit(SEED_C, 3));
        rst_oe_c = 0; #1;
        chk("R8", "low pin resets active-low part", oe_c, 0);
        @(negedge clk);
        rst_oe_c = 1; #1;
        chk("R8", "restart at bit 0 active-low part", data_c, ref_bit(SEED_C, 0));
    endtask

    initial begin
        ser_en = 1; ce_n_a = 1; rst_oe = 1;
        ce_n_c = 0; rst_oe_c = 0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_chain_read();
        t_follow();
        t_reset_midread();
        t_standby();
        t_serial_off();
        t_polarity();
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule